// File: doc/BRIEF.md
# CEC Message Mailbox Register Bank

This block is a word-addressed register file. It sits between a host register port and a CEC line engine. The host builds an outgoing message in three parts: a byte-count register, an opcode register and packed payload words. The launch comes last: writing the header register hands the whole message to the line engine, which holds its request until it reports completion. Incoming messages from the line engine are latched into a matching set of receive registers for the host to read.

Six sticky event bits record reception, receive error, sent, transmit error, no-acknowledge and receive overflow. They are cleared by writing ones. Any event also sets a CEC summary flag in a second status word. A level interrupt stays high while a summary flag is set and its enable bit is on.

The register port is a one-cycle write strobe with combinational read data selected by address. The transmit side is a two-state machine: `TX_IDLE` goes to `TX_PEND` on a header write, and `TX_PEND` returns to `TX_IDLE` on `tx_done`. The receive side is a two-state machine: `RX_EMPTY` goes to `RX_HELD` when a message is accepted, and `RX_HELD` returns to `RX_EMPTY` when the host writes 1 to the received bit.

Top module: `cec_mbox_regs`

## Requirements
- R1: After reset the register reads are as follows: address 0x00 reads parameter `VERSION` (default 0x0F0B), 0x29 reads 0x000F (unregistered), and 0x01, 0x03 and 0x28 read 0. Outputs `irq` and `tx_req` are low.
- R2: Address 0x01 (enable) keeps only bit 12 (CEC) and bit 13 (IR). Address 0x29 keeps only bits 3:0. All other bits read 0.
- R3: A write to 0x3D in `TX_IDLE` raises `tx_req` one cycle later. The header, opcode (0x34), length (0x35, opcode plus payload bytes, so 0 means header only) and payload words (0x36 upward) appear on the `tx_*` outputs and read back. In each payload word the earlier byte is in bits 7:0 and the next byte in bits 15:8.
- R4: While `tx_req` is high, writes to 0x34–0x3D change no register and launch nothing.
- R5: `tx_done` while `tx_req` is high drops `tx_req` in the next cycle and sets status bit 2 (sent). It also sets bit 3 if `tx_err` is high and bit 4 if `tx_nack` is high.
- R6: `rx_valid` in `RX_EMPTY` captures the header (0x33), opcode (0x2A) and data words (0x2C upward), and sets status bit 0. It sets bit 1 if `rx_err` is high. If `rx_len` exceeds 15 it sets bit 5 and stores 15 in 0x2B; otherwise 0x2B stores `rx_len`.
- R7: `rx_valid` in `RX_HELD` (status bit 0 set) changes no receive register and no status bit.
- R8: Writing 1 to a bit of 0x28 (bits 5:0) or of 0x03 (bits 12, 13) clears that bit. Writing 0 leaves it unchanged.
- R9: Summary bit 12 of 0x03 sets in any cycle in which a status bit of 0x28 sets.
- R10: When a status or summary bit is set and cleared in the same cycle, it ends up set.
- R11: `irq` is high exactly while 0x03 ANDed with 0x01 is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host write strobe |
| reg_addr | input | 8 | Host word address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| tx_req | output | 1 | Transmit request to the line engine |
| tx_hdr | output | 8 | Header byte to send |
| tx_opc | output | 8 | Opcode byte to send |
| tx_len | output | 4 | Opcode plus payload byte count |
| tx_data | output | 112 | Payload words, word 0 in bits 15:0 |
| tx_done | input | 1 | Line engine finished the transmit |
| tx_err | input | 1 | Transmit failed, valid with `tx_done` |
| tx_nack | input | 1 | Transmit not acknowledged, valid with `tx_done` |
| rx_valid | input | 1 | Received message is on the `rx_*` inputs |
| rx_hdr | input | 8 | Received header byte |
| rx_opc | input | 8 | Received opcode byte |
| rx_len | input | 5 | Received opcode plus payload byte count |
| rx_data | input | 112 | Received payload words |
| rx_err | input | 1 | Message received with errors |

## Verification
Host write-one-to-clear writes and hardware event setting can land on the same status bit in the same clock. The bench forces this overlap twice. In the first case, one host write clears the sent, received and overflow bits in the same cycle as a `tx_done` with error. This must leave sent and error set while the receive bits clear. In the second case, a summary clear lands in the same cycle as a fresh receive, and the summary flag must survive. A behavioural reference model, run every clock, judges `irq` and `tx_req`, and literal register reads confirm the final bit patterns.

// File: rtl/cec_mbox_pkg.sv
package cec_mbox_pkg;
    localparam logic [7:0] A_VERSION = 8'h00;
    localparam logic [7:0] A_ENABLE  = 8'h01;
    localparam logic [7:0] A_SUMMARY = 8'h03;
    localparam logic [7:0] A_STATUS  = 8'h28;
    localparam logic [7:0] A_LADDR   = 8'h29;
    localparam logic [7:0] A_RX_OPC  = 8'h2A;
    localparam logic [7:0] A_RX_LEN  = 8'h2B;
    localparam logic [7:0] A_RX_DATA = 8'h2C;
    localparam logic [7:0] A_RX_HDR  = 8'h33;
    localparam logic [7:0] A_TX_OPC  = 8'h34;
    localparam logic [7:0] A_TX_LEN  = 8'h35;
    localparam logic [7:0] A_TX_DATA = 8'h36;
    localparam logic [7:0] A_TX_HDR  = 8'h3D;

    localparam int SB_RCVD = 0;
    localparam int SB_RERR = 1;
    localparam int SB_SENT = 2;
    localparam int SB_TERR = 3;
    localparam int SB_NACK = 4;
    localparam int SB_OVF  = 5;
    localparam int NUM_SB  = 6;

    localparam int EN_CEC_BIT = 12;
    localparam int EN_IR_BIT  = 13;

    typedef enum logic {TX_IDLE, TX_PEND} tx_state_t;
    typedef enum logic {RX_EMPTY, RX_HELD} rx_state_t;
endpackage

// File: rtl/cec_mbox_tx.sv
module cec_mbox_tx
    import cec_mbox_pkg::*;
#(
    parameter int DW = 16,
    parameter int NW = 7,
    parameter int LW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_len,
    input  logic            wr_opc,
    input  logic            wr_hdr,
    input  logic [NW-1:0]   wr_word,
    input  logic [DW-1:0]   wdata,
    input  logic            line_done,
    input  logic            line_err,
    input  logic            line_nack,
    output logic            req,
    output logic [7:0]      hdr_q,
    output logic [7:0]      opc_q,
    output logic [LW-1:0]   len_q,
    output logic [NW*DW-1:0] data_q,
    output logic            set_sent,
    output logic            set_terr,
    output logic            set_nack
);
    tx_state_t state, nxt;
    logic [DW-1:0] words [NW];

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            TX_IDLE: if (wr_hdr)    nxt = TX_PEND;
            TX_PEND: if (line_done) nxt = TX_IDLE;
        endcase
    end

    always_comb begin
        req      = 1'b0;
        set_sent = 1'b0;
        set_terr = 1'b0;
        set_nack = 1'b0;
        unique case (state)
            TX_IDLE: ;
            TX_PEND: begin
                req      = 1'b1;
                set_sent = line_done;
                set_terr = line_done && line_err;
                set_nack = line_done && line_nack;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q <= '0;
            opc_q <= '0;
            len_q <= '0;
        end else if (state == TX_IDLE) begin
            if (wr_hdr) hdr_q <= wdata[7:0];
            if (wr_opc) opc_q <= wdata[7:0];
            if (wr_len) len_q <= wdata[LW-1:0];
        end
    end

    for (genvar i = 0; i < NW; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)                            words[i] <= '0;
            else if (state == TX_IDLE && wr_word[i]) words[i] <= wdata;
        end
        assign data_q[i*DW +: DW] = words[i];
    end

    // R3: a header write from idle launches the request
    a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && wr_hdr) |=> req);
    // R4: message registers frozen while the request is up
    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> ($stable(hdr_q) && $stable(opc_q) && $stable(len_q) && $stable(data_q)));
    // R5: completion releases the request
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (req && line_done) |=> !req);
endmodule

// File: rtl/cec_mbox_rx.sv
module cec_mbox_rx
    import cec_mbox_pkg::*;
#(
    parameter int DW = 16,
    parameter int NW = 7,
    parameter int LW = 4,
    parameter int MAX_LEN = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_valid,
    input  logic [7:0]       line_hdr,
    input  logic [7:0]       line_opc,
    input  logic [LW:0]      line_len,
    input  logic [NW*DW-1:0] line_data,
    input  logic             line_err,
    input  logic             clr_rcvd,
    output logic             held,
    output logic [7:0]       hdr_q,
    output logic [7:0]       opc_q,
    output logic [LW-1:0]    len_q,
    output logic [NW*DW-1:0] data_q,
    output logic             set_rcvd,
    output logic             set_rerr,
    output logic             set_ovf
);
    rx_state_t state, nxt;
    logic accept;
    logic too_long;

    assign too_long = (int'(line_len) > MAX_LEN);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_EMPTY;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_EMPTY: if (line_valid) nxt = RX_HELD;
            RX_HELD:  if (clr_rcvd)   nxt = RX_EMPTY;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        held     = 1'b0;
        unique case (state)
            RX_EMPTY: accept = line_valid;
            RX_HELD:  held   = 1'b1;
        endcase
        set_rcvd = accept;
        set_rerr = accept && line_err;
        set_ovf  = accept && too_long;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q  <= '0;
            opc_q  <= '0;
            len_q  <= '0;
            data_q <= '0;
        end else if (accept) begin
            hdr_q  <= line_hdr;
            opc_q  <= line_opc;
            len_q  <= too_long ? LW'(MAX_LEN) : line_len[LW-1:0];
            data_q <= line_data;
        end
    end

    // R7: a held message is never overwritten
    a_r7_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> ($stable(hdr_q) && $stable(opc_q) && $stable(len_q) && $stable(data_q)));
endmodule

// File: rtl/cec_mbox_status.sv
module cec_mbox_status
    import cec_mbox_pkg::*;
#(
    parameter int NSB = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NSB-1:0] set_vec,
    input  logic           st_wr,
    input  logic [NSB-1:0] st_wbits,
    input  logic           sum_wr,
    input  logic [1:0]     sum_wbits,
    input  logic           en_wr,
    input  logic [1:0]     en_wbits,
    output logic [NSB-1:0] st_q,
    output logic [1:0]     sum_q,
    output logic [1:0]     en_q,
    output logic           irq
);
    logic [NSB-1:0] st_clr;
    logic [1:0]     sum_clr;

    assign st_clr  = st_wr  ? st_wbits  : '0;
    assign sum_clr = sum_wr ? sum_wbits : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= '0;
            sum_q <= '0;
            en_q  <= '0;
        end else begin
            st_q     <= (st_q & ~st_clr) | set_vec;
            sum_q[0] <= (sum_q[0] & ~sum_clr[0]) | (|set_vec);
            sum_q[1] <= sum_q[1] & ~sum_clr[1];
            if (en_wr) en_q <= en_wbits;
        end
    end

    assign irq = |(sum_q & en_q);

    // R9 and R10: any event leaves the summary flag set, clear or not
    a_r9_summary: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> sum_q[0]);
    // R10: an event on the sent bit wins over a clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[SB_SENT] |=> st_q[SB_SENT]);
    // R8: a clear without an event empties the bit
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && st_wbits[SB_SENT] && !set_vec[SB_SENT]) |=> !st_q[SB_SENT]);
endmodule

// File: rtl/cec_mbox_regs.sv
module cec_mbox_regs
    import cec_mbox_pkg::*;
#(
    parameter int NUM_WORDS = 7,
    parameter int WORD_W = 16,
    parameter logic [WORD_W-1:0] VERSION = 16'h0F0B,
    localparam int MAX_LEN = 2 * NUM_WORDS + 1,
    localparam int LW = $clog2(MAX_LEN + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [7:0]                  reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    output logic                        irq,
    output logic                        tx_req,
    output logic [7:0]                  tx_hdr,
    output logic [7:0]                  tx_opc,
    output logic [LW-1:0]               tx_len,
    output logic [NUM_WORDS*WORD_W-1:0] tx_data,
    input  logic                        tx_done,
    input  logic                        tx_err,
    input  logic                        tx_nack,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_hdr,
    input  logic [7:0]                  rx_opc,
    input  logic [LW:0]                 rx_len,
    input  logic [NUM_WORDS*WORD_W-1:0] rx_data,
    input  logic                        rx_err
);
    logic [NUM_WORDS-1:0]        tx_wr_word;
    logic                        wr_tx_len, wr_tx_opc, wr_tx_hdr;
    logic                        wr_status, wr_summary, wr_enable, wr_laddr;
    logic                        rx_held, clr_rcvd;
    logic [7:0]                  rx_hdr_q, rx_opc_q;
    logic [LW-1:0]               rx_len_q;
    logic [NUM_WORDS*WORD_W-1:0] rx_data_q;
    logic                        s_rcvd, s_rerr, s_ovf, s_sent, s_terr, s_nack;
    logic [NUM_SB-1:0]           set_vec;
    logic [NUM_SB-1:0]           st_q;
    logic [1:0]                  sum_q, en_q;
    logic [3:0]                  laddr_q;

    assign wr_tx_len  = reg_wr && (reg_addr == A_TX_LEN);
    assign wr_tx_opc  = reg_wr && (reg_addr == A_TX_OPC);
    assign wr_tx_hdr  = reg_wr && (reg_addr == A_TX_HDR);
    assign wr_status  = reg_wr && (reg_addr == A_STATUS);
    assign wr_summary = reg_wr && (reg_addr == A_SUMMARY);
    assign wr_enable  = reg_wr && (reg_addr == A_ENABLE);
    assign wr_laddr   = reg_wr && (reg_addr == A_LADDR);
    assign clr_rcvd   = wr_status && reg_wdata[SB_RCVD];

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_txdec
        assign tx_wr_word[i] = reg_wr && (reg_addr == 8'(A_TX_DATA + i));
    end

    cec_mbox_tx #(.DW(WORD_W), .NW(NUM_WORDS), .LW(LW)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_len    (wr_tx_len),
        .wr_opc    (wr_tx_opc),
        .wr_hdr    (wr_tx_hdr),
        .wr_word   (tx_wr_word),
        .wdata     (reg_wdata),
        .line_done (tx_done),
        .line_err  (tx_err),
        .line_nack (tx_nack),
        .req       (tx_req),
        .hdr_q     (tx_hdr),
        .opc_q     (tx_opc),
        .len_q     (tx_len),
        .data_q    (tx_data),
        .set_sent  (s_sent),
        .set_terr  (s_terr),
        .set_nack  (s_nack)
    );

    cec_mbox_rx #(.DW(WORD_W), .NW(NUM_WORDS), .LW(LW), .MAX_LEN(MAX_LEN)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_valid (rx_valid),
        .line_hdr   (rx_hdr),
        .line_opc   (rx_opc),
        .line_len   (rx_len),
        .line_data  (rx_data),
        .line_err   (rx_err),
        .clr_rcvd   (clr_rcvd),
        .held       (rx_held),
        .hdr_q      (rx_hdr_q),
        .opc_q      (rx_opc_q),
        .len_q      (rx_len_q),
        .data_q     (rx_data_q),
        .set_rcvd   (s_rcvd),
        .set_rerr   (s_rerr),
        .set_ovf    (s_ovf)
    );

    always_comb begin
        set_vec          = '0;
        set_vec[SB_RCVD] = s_rcvd;
        set_vec[SB_RERR] = s_rerr;
        set_vec[SB_SENT] = s_sent;
        set_vec[SB_TERR] = s_terr;
        set_vec[SB_NACK] = s_nack;
        set_vec[SB_OVF]  = s_ovf;
    end

    cec_mbox_status #(.NSB(NUM_SB)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .st_wr     (wr_status),
        .st_wbits  (reg_wdata[NUM_SB-1:0]),
        .sum_wr    (wr_summary),
        .sum_wbits ({reg_wdata[EN_IR_BIT], reg_wdata[EN_CEC_BIT]}),
        .en_wr     (wr_enable),
        .en_wbits  ({reg_wdata[EN_IR_BIT], reg_wdata[EN_CEC_BIT]}),
        .st_q      (st_q),
        .sum_q     (sum_q),
        .en_q      (en_q),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)        laddr_q <= 4'hF;
        else if (wr_laddr) laddr_q <= reg_wdata[3:0];
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_VERSION: reg_rdata = VERSION;
            A_ENABLE: begin
                reg_rdata[EN_CEC_BIT] = en_q[0];
                reg_rdata[EN_IR_BIT]  = en_q[1];
            end
            A_SUMMARY: begin
                reg_rdata[EN_CEC_BIT] = sum_q[0];
                reg_rdata[EN_IR_BIT]  = sum_q[1];
            end
            A_STATUS:  reg_rdata[NUM_SB-1:0] = st_q;
            A_LADDR:   reg_rdata[3:0]        = laddr_q;
            A_RX_OPC:  reg_rdata[7:0]        = rx_opc_q;
            A_RX_LEN:  reg_rdata[LW-1:0]     = rx_len_q;
            A_RX_HDR:  reg_rdata[7:0]        = rx_hdr_q;
            A_TX_OPC:  reg_rdata[7:0]        = tx_opc;
            A_TX_LEN:  reg_rdata[LW-1:0]     = tx_len;
            A_TX_HDR:  reg_rdata[7:0]        = tx_hdr;
            default: ;
        endcase
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (reg_addr == 8'(A_RX_DATA + i)) reg_rdata = rx_data_q[i*WORD_W +: WORD_W];
            if (reg_addr == 8'(A_TX_DATA + i)) reg_rdata = tx_data[i*WORD_W +: WORD_W];
        end
    end

    // R7: receive state and received bit move together
    a_r7_held_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        rx_held == st_q[SB_RCVD]);
    // R6: an overlong accepted message flags overflow
    a_r6_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_held && (int'(rx_len) > MAX_LEN)) |=> st_q[SB_OVF]);
    // R2: the logical address never leaves its four bits
    a_r2_laddr_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_laddr |=> (laddr_q == $past(reg_wdata[3:0])));
endmodule

// File: tb/cec_mbox_regs_tb.sv
module cec_mbox_regs_tb;
    localparam int NW = 7;
    localparam int DW = 16;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic irq, tx_req;
    logic [7:0] tx_hdr, tx_opc;
    logic [LW-1:0] tx_len;
    logic [NW*DW-1:0] tx_data;
    logic tx_done = 0, tx_err = 0, tx_nack = 0;
    logic rx_valid = 0, rx_err = 0;
    logic [7:0] rx_hdr = '0, rx_opc = '0;
    logic [LW:0] rx_len = '0;
    logic [NW*DW-1:0] rx_data = '0;

    int nchk = 0;
    int nerr = 0;

    logic [5:0] m_st;
    logic m_sum, m_pend;
    logic [1:0] m_en;
    logic [5:0] t_set, t_clr;

    always #5 clk = ~clk;

    cec_mbox_regs u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_req(tx_req), .tx_hdr(tx_hdr), .tx_opc(tx_opc), .tx_len(tx_len),
        .tx_data(tx_data), .tx_done(tx_done), .tx_err(tx_err), .tx_nack(tx_nack),
        .rx_valid(rx_valid), .rx_hdr(rx_hdr), .rx_opc(rx_opc), .rx_len(rx_len),
        .rx_data(rx_data), .rx_err(rx_err)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference: status, summary, enable, pending
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= '0; m_sum <= 1'b0; m_en <= '0; m_pend <= 1'b0;
        end else begin
            t_set = '0;
            if (m_pend && tx_done)
                t_set = t_set | 6'h04 | (tx_err ? 6'h08 : 6'h00) | (tx_nack ? 6'h10 : 6'h00);
            if (!m_st[0] && rx_valid)
                t_set = t_set | 6'h01 | (rx_err ? 6'h02 : 6'h00) | (rx_len > 15 ? 6'h20 : 6'h00);
            t_clr = (reg_wr && reg_addr == 8'h28) ? reg_wdata[5:0] : 6'h00;
            m_st  <= (m_st & ~t_clr) | t_set;
            m_sum <= (m_sum && !(reg_wr && reg_addr == 8'h03 && reg_wdata[12])) || (t_set != 0);
            if (reg_wr && reg_addr == 8'h01) m_en <= {reg_wdata[13], reg_wdata[12]};
            if (!m_pend && reg_wr && reg_addr == 8'h3D) m_pend <= 1'b1;
            else if (m_pend && tx_done)                 m_pend <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 irq vs model", irq, m_sum && m_en[0]);
            chk("R5 tx_req vs model", tx_req, m_pend);
        end
    end

    task automatic wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, logic [15:0] exp, string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic done_pulse(logic e, logic n);
        @(negedge clk);
        tx_done = 1; tx_err = e; tx_nack = n;
        @(negedge clk);
        tx_done = 0; tx_err = 0; tx_nack = 0;
    endtask

    task automatic rx_pulse(logic [7:0] h, logic [7:0] o, logic [4:0] l, logic e,
                            logic [NW*DW-1:0] d);
        @(negedge clk);
        rx_valid = 1; rx_hdr = h; rx_opc = o; rx_len = l; rx_err = e; rx_data = d;
        @(negedge clk);
        rx_valid = 0; rx_err = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(8'h00, 16'h0F0B, "R1 version");
        rd(8'h29, 16'h000F, "R1 laddr");
        rd(8'h01, 16'h0000, "R1 enable");
        rd(8'h03, 16'h0000, "R1 summary");
        rd(8'h28, 16'h0000, "R1 status");
        chk("R1 irq", irq, 1'b0);
        chk("R1 tx_req", tx_req, 1'b0);
        // R2 masking
        wr(8'h01, 16'hFFFF);
        rd(8'h01, 16'h3000, "R2 enable mask");
        wr(8'h29, 16'h1234);
        rd(8'h29, 16'h0004, "R2 laddr mask");
        // R3 launch
        wr(8'h35, 16'h0003);
        wr(8'h34, 16'h0036);
        wr(8'h36, 16'hBBAA);
        wr(8'h3D, 16'h0040);
        chk("R3 tx_req up", tx_req, 1'b1);
        chk("R3 tx_hdr", tx_hdr, 8'h40);
        chk("R3 tx_opc", tx_opc, 8'h36);
        chk("R3 tx_len", tx_len, 4'd3);
        chk("R3 byte order", tx_data[15:0], 16'hBBAA);
        // R4 writes ignored while pending
        wr(8'h35, 16'h0009);
        wr(8'h36, 16'h1111);
        wr(8'h3D, 16'h0055);
        rd(8'h35, 16'h0003, "R4 len kept");
        rd(8'h36, 16'hBBAA, "R4 data kept");
        rd(8'h3D, 16'h0040, "R4 hdr kept");
        chk("R4 tx_hdr port", tx_hdr, 8'h40);
        // R5 completion with nack
        done_pulse(1'b0, 1'b1);
        chk("R5 tx_req down", tx_req, 1'b0);
        rd(8'h28, 16'h0014, "R5 sent+nack");
        rd(8'h03, 16'h1000, "R9 summary set");
        chk("R11 irq high", irq, 1'b1);
        // R8 write-one-to-clear
        wr(8'h28, 16'h0004);
        rd(8'h28, 16'h0010, "R8 partial clear");
        wr(8'h28, 16'h0010);
        rd(8'h28, 16'h0000, "R8 full clear");
        wr(8'h03, 16'h1000);
        rd(8'h03, 16'h0000, "R8 summary clear");
        chk("R11 irq low", irq, 1'b0);
        // R6 capture with overflow
        rx_pulse(8'h04, 8'h82, 5'd20, 1'b0, {16'hEEDD, 64'h0, 16'h4433, 16'h2211});
        rd(8'h33, 16'h0004, "R6 rx hdr");
        rd(8'h2A, 16'h0082, "R6 rx opc");
        rd(8'h2B, 16'h000F, "R6 rx len clipped");
        rd(8'h2C, 16'h2211, "R6 rx word0");
        rd(8'h32, 16'hEEDD, "R6 rx word6");
        rd(8'h28, 16'h0021, "R6 rcvd+ovf");
        // R7 second message ignored while held
        rx_pulse(8'h99, 8'h11, 5'd2, 1'b1, '1);
        rd(8'h33, 16'h0004, "R7 hdr kept");
        rd(8'h2B, 16'h000F, "R7 len kept");
        rd(8'h2C, 16'h2211, "R7 word kept");
        rd(8'h28, 16'h0021, "R7 status kept");
        // R10 clear and tx completion in one cycle; header-only launch
        wr(8'h35, 16'h0000);
        wr(8'h3D, 16'h004F);
        chk("R3 header only len", tx_len, 4'd0);
        @(negedge clk);
        reg_wr = 1; reg_addr = 8'h28; reg_wdata = 16'h0025;
        tx_done = 1; tx_err = 1;
        @(negedge clk);
        reg_wr = 0; tx_done = 0; tx_err = 0;
        rd(8'h28, 16'h000C, "R10 set wins on status");
        // R10 summary clear and new receive in one cycle
        @(negedge clk);
        reg_wr = 1; reg_addr = 8'h03; reg_wdata = 16'h1000;
        rx_valid = 1; rx_hdr = 8'h10; rx_opc = 8'h44; rx_len = 5'd1; rx_err = 0;
        @(negedge clk);
        reg_wr = 0; rx_valid = 0;
        rd(8'h03, 16'h1000, "R10 set wins on summary");
        rd(8'h28, 16'h000D, "R10 status after rx");
        rd(8'h2B, 16'h0001, "R6 rx len plain");
        rd(8'h33, 16'h0010, "R6 rx hdr new");
        // R6 error flag
        wr(8'h28, 16'h003F);
        rx_pulse(8'h01, 8'h00, 5'd0, 1'b1, '0);
        rd(8'h28, 16'h0003, "R6 rcvd+rxerr");
        rd(8'h2B, 16'h0000, "R6 rx len zero");
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule